// File: doc/BRIEF.md
# DRAM Bank State and Latency Tracker

This block holds the timing state of every bank in a single-channel DRAM controller. For each bank it keeps the row that is open, if any. It also keeps three cycle stamps: when the bank is next idle, when the minimum active time of the current row ends, and the earliest cycle at which a new activate may be issued. A free-running 32-bit cycle counter supplies the notion of "now".

The block has two duties. A scheduler can strobe a query for a bank and row, and one cycle later it gets an estimate of the access latency. When the scheduler commits an access, it presents an issue event, and the bank's state is advanced under the selected page policy. The policy is keep-open, adaptive keep-open or close-after-access. In adaptive mode, an external decision unit may ask for the row to be closed after the access through an auto-precharge input.

Timing values (precharge, activate-to-read, read latency, minimum row-active time) are module parameters counted in clock cycles. An activate issued on a row miss is placed at the end of the access, less the activate-to-read and read latencies. The caller must therefore give an access latency of at least their sum on a miss.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset, every bank has no open row and all of its time stamps at zero, `lat_valid` is low and `cycle_now` is 0.
- R2: `cycle_now` advances by one each clock outside reset. Queries and issues take its value at the sampling edge as the current cycle.
- R3: For a query strobed at a clock edge, `lat` and a one-cycle `lat_valid` pulse appear after that edge. `lat_valid` stays low in cycles that follow no query.
- R4: In keep-open (`page_mode`=0) or adaptive (`page_mode`=1) mode, a query whose row matches the bank's open row returns the wait until the bank is idle plus TCL. Whether the minimum active time has elapsed has no effect.
- R5: A query that misses an open row returns the sum of: the wait until the bank is idle, any stall until the activate-allowed cycle, TRP, TRCD and TCL. The stall is measured from now plus the wait plus TRP.
- R6: A query to a bank with no open row leaves out the precharge term. It returns the wait until idle, plus any stall to the activate-allowed cycle measured from now plus the wait, plus TRCD plus TCL.
- R7: An issue in keep-open or adaptive mode opens the given row and sets the idle cycle to now plus added delay plus access latency. On a miss, the activate cycle is that end cycle minus TRCD minus TCL. The minimum-active end is the activate cycle plus TRAS, and the next activate is allowed at the activate cycle plus TRAS plus TRP.
- R8: In adaptive mode with `iss_auto_pre` high, the issue leaves the bank with no open row. The idle cycle becomes the larger of the new idle cycle and the minimum-active end, plus TRP.
- R9: In keep-open mode `iss_auto_pre` has no effect, and the row stays open.
- R10: In close mode (`page_mode` 2 or 3), every query is estimated as a miss with no precharge term. Every issue leaves the bank closed, with the idle cycle set to the larger of the access end and the minimum-active end, plus TRP.
- R11: A query and an issue to the same bank in the same cycle: the query is estimated from the state before that issue.
- R12: An issue changes only the state of the bank it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_mode | input | 2 | 0 keep-open, 1 adaptive, 2 or 3 close |
| q_valid | input | 1 | Latency query strobe |
| q_bank | input | 3 | Queried bank |
| q_row | input | 14 | Queried row |
| iss_valid | input | 1 | Access issue strobe |
| iss_bank | input | 3 | Bank of the issued access |
| iss_row | input | 14 | Row of the issued access |
| iss_add_dly | input | 16 | Extra delay before the access starts |
| iss_acc_lat | input | 16 | Access latency of the issued access |
| iss_auto_pre | input | 1 | Close request from the decision unit (adaptive mode only) |
| lat_valid | output | 1 | Estimate valid, one cycle after a query |
| lat | output | 32 | Estimated latency in cycles |
| cycle_now | output | 32 | Free-running cycle counter |

## Verification
A latency query and an issue event can land on the same bank in one cycle. The estimator reads the registered bank state while the updater writes it, so the query must see the old state. The bench drives both strobes in one cycle on a bank with no open row. The estimate must be the closed-bank miss cost, not the row-hit cost. A query on the next cycle must then show the row-hit latency of the freshly opened row.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    localparam int TIME_W = 32;
    localparam int ROW_W  = 14;
    localparam int DLY_W  = 16;

    typedef enum logic [1:0] {
        PG_OPEN  = 2'd0,
        PG_ADAPT = 2'd1,
        PG_CLOSE = 2'd2
    } page_mode_e;

    typedef logic [TIME_W-1:0] cyc_t;

    typedef struct packed {
        logic             row_vld;
        logic [ROW_W-1:0] row;
        cyc_t             free_at;
        cyc_t             ras_done_at;
        cyc_t             act_ok_at;
    } bank_state_t;

    function automatic logic keeps_open(input page_mode_e m);
        return (m == PG_OPEN) || (m == PG_ADAPT);
    endfunction

    function automatic cyc_t sat_diff(input cyc_t a, input cyc_t b);
        return (a > b) ? (a - b) : '0;
    endfunction

    function automatic cyc_t cyc_max(input cyc_t a, input cyc_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bank_lat_est.sv
module bank_lat_est
    import bank_trk_pkg::*;
#(
    parameter int TRP  = 4,
    parameter int TRCD = 4,
    parameter int TCL  = 5
) (
    input  bank_state_t      st,
    input  cyc_t             now,
    input  logic [ROW_W-1:0] row,
    input  page_mode_e       mode,
    output cyc_t             lat
);
    localparam cyc_t C_RP  = cyc_t'(TRP);
    localparam cyc_t C_RCD = cyc_t'(TRCD);
    localparam cyc_t C_CL  = cyc_t'(TCL);

    cyc_t idle_wait;
    cyc_t pre_cost;
    cyc_t act_try;
    cyc_t act_stall;
    logic row_hit;

    always_comb begin
        idle_wait = sat_diff(st.free_at, now);
        row_hit   = keeps_open(mode) && st.row_vld && (st.row == row);
        pre_cost  = (keeps_open(mode) && st.row_vld) ? C_RP : '0;
        act_try   = now + idle_wait + pre_cost;
        act_stall = sat_diff(st.act_ok_at, act_try);
        if (row_hit) begin
            lat = idle_wait + C_CL;
        end else begin
            lat = idle_wait + act_stall + pre_cost + C_RCD + C_CL;
        end
    end

endmodule

// File: rtl/bank_state_upd.sv
module bank_state_upd
    import bank_trk_pkg::*;
#(
    parameter int TRP  = 4,
    parameter int TRCD = 4,
    parameter int TCL  = 5,
    parameter int TRAS = 10
) (
    input  bank_state_t      st,
    input  cyc_t             now,
    input  logic [ROW_W-1:0] row,
    input  logic [DLY_W-1:0] add_dly,
    input  logic [DLY_W-1:0] acc_lat,
    input  logic             auto_pre,
    input  page_mode_e       mode,
    output bank_state_t      nxt
);
    localparam cyc_t C_RP     = cyc_t'(TRP);
    localparam cyc_t C_RD_OFS = cyc_t'(TRCD + TCL);
    localparam cyc_t C_RAS    = cyc_t'(TRAS);
    localparam cyc_t C_RC     = cyc_t'(TRAS + TRP);

    cyc_t end_at;
    cyc_t act_at;
    logic opens_row;

    always_comb begin
        end_at    = now + cyc_t'(add_dly) + cyc_t'(acc_lat);
        act_at    = end_at - C_RD_OFS;
        opens_row = !(keeps_open(mode) && st.row_vld && (st.row == row));
        nxt       = st;
        if (opens_row) begin
            nxt.ras_done_at = act_at + C_RAS;
            nxt.act_ok_at   = act_at + C_RC;
        end
        if (keeps_open(mode)) begin
            nxt.row_vld = 1'b1;
            nxt.row     = row;
            nxt.free_at = end_at;
            if ((mode == PG_ADAPT) && auto_pre) begin
                nxt.row_vld = 1'b0;
                nxt.free_at = cyc_max(end_at, nxt.ras_done_at) + C_RP;
            end
        end else begin
            nxt.row_vld = 1'b0;
            nxt.row     = row;
            nxt.free_at = cyc_max(end_at, nxt.ras_done_at) + C_RP;
        end
    end

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TRP       = 4,
    parameter int TRCD      = 4,
    parameter int TCL       = 5,
    parameter int TRAS      = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   page_mode,
    input  logic                         q_valid,
    input  logic [$clog2(NUM_BANKS)-1:0] q_bank,
    input  logic [ROW_W-1:0]             q_row,
    input  logic                         iss_valid,
    input  logic [$clog2(NUM_BANKS)-1:0] iss_bank,
    input  logic [ROW_W-1:0]             iss_row,
    input  logic [DLY_W-1:0]             iss_add_dly,
    input  logic [DLY_W-1:0]             iss_acc_lat,
    input  logic                         iss_auto_pre,
    output logic                         lat_valid,
    output logic [TIME_W-1:0]            lat,
    output logic [TIME_W-1:0]            cycle_now
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    page_mode_e            mode;
    bank_state_t           bank_q [NUM_BANKS];
    bank_state_t           upd_nxt;
    cyc_t                  est_lat;
    logic [NUM_BANKS-1:0]  open_vec;

    assign mode = page_mode_e'(page_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_now <= '0;
        end else begin
            cycle_now <= cycle_now + 1'b1;
        end
    end

    bank_lat_est #(.TRP(TRP), .TRCD(TRCD), .TCL(TCL)) u_est (
        .st   (bank_q[q_bank]),
        .now  (cycle_now),
        .row  (q_row),
        .mode (mode),
        .lat  (est_lat)
    );

    bank_state_upd #(.TRP(TRP), .TRCD(TRCD), .TCL(TCL), .TRAS(TRAS)) u_upd (
        .st       (bank_q[iss_bank]),
        .now      (cycle_now),
        .row      (iss_row),
        .add_dly  (iss_add_dly),
        .acc_lat  (iss_acc_lat),
        .auto_pre (iss_auto_pre),
        .mode     (mode),
        .nxt      (upd_nxt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[b] <= '0;
            end else if (iss_valid && (iss_bank == BANK_W'(b))) begin
                bank_q[b] <= upd_nxt;
            end
        end
        assign open_vec[b] = bank_q[b].row_vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_valid <= 1'b0;
            lat       <= '0;
        end else begin
            lat_valid <= q_valid;
            if (q_valid) begin
                lat <= est_lat;
            end
        end
    end

endmodule

// File: rtl/bank_trk_checker.sv
module bank_trk_checker #(
    parameter int NUM_BANKS = 8,
    parameter int TCL       = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic [1:0]                   page_mode,
    input logic                         q_valid,
    input logic                         iss_valid,
    input logic [$clog2(NUM_BANKS)-1:0] iss_bank,
    input logic                         iss_auto_pre,
    input logic                         lat_valid,
    input logic [31:0]                  lat,
    input logic [NUM_BANKS-1:0]         open_vec
);
    assert_lat_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> lat_valid);

    assert_lat_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> !lat_valid);

    assert_lat_floor_R4: assert property (@(posedge clk) disable iff (rst)
        lat_valid |-> (lat >= 32'(TCL)));

    assert_open_sets_row_R7: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && page_mode == 2'd0) |=> open_vec[$past(iss_bank)]);

    assert_auto_pre_closes_R8: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && page_mode == 2'd1 && iss_auto_pre) |=> !open_vec[$past(iss_bank)]);

    assert_close_mode_shut_R10: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && page_mode[1]) |=> !open_vec[$past(iss_bank)]);

endmodule

bind bank_timing_tracker bank_trk_checker #(
    .NUM_BANKS (NUM_BANKS),
    .TCL       (TCL)
) u_bank_trk_checker (
    .clk          (clk),
    .rst          (rst),
    .page_mode    (page_mode),
    .q_valid      (q_valid),
    .iss_valid    (iss_valid),
    .iss_bank     (iss_bank),
    .iss_auto_pre (iss_auto_pre),
    .lat_valid    (lat_valid),
    .lat          (lat),
    .open_vec     (open_vec)
);

// File: tb/test_bank_timing_tracker.sv
`timescale 1ns/1ps
module test_bank_timing_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  page_mode = 2'd0;
    logic        q_valid = 1'b0;
    logic [2:0]  q_bank = '0;
    logic [13:0] q_row = '0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_bank = '0;
    logic [13:0] iss_row = '0;
    logic [15:0] iss_add_dly = '0;
    logic [15:0] iss_acc_lat = '0;
    logic        iss_auto_pre = 1'b0;
    logic        lat_valid;
    logic [31:0] lat;
    logic [31:0] cycle_now;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bank_timing_tracker #(
        .NUM_BANKS(8), .TRP(4), .TRCD(4), .TCL(5), .TRAS(10)
    ) i_bank_timing_tracker (
        .clk(clk), .rst(rst), .page_mode(page_mode),
        .q_valid(q_valid), .q_bank(q_bank), .q_row(q_row),
        .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_row(iss_row),
        .iss_add_dly(iss_add_dly), .iss_acc_lat(iss_acc_lat),
        .iss_auto_pre(iss_auto_pre),
        .lat_valid(lat_valid), .lat(lat), .cycle_now(cycle_now)
    );

    typedef struct packed {
        int       at;
        bit       q;
        bit       i;
        bit [1:0] mode;
        int       bank;
        int       row;
        int       add;
        int       acc;
        bit       ap;
        int       exp;
        int       req;
    } vec_t;

    // Timing: TRP=4 TRCD=4 TCL=5 TRAS=10; mode 0 open, 1 adaptive, 2 close
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{10, 1'b1, 1'b0, 2'd0, 0, 5, 0,  0, 1'b0,  9,  6}, // R6 reset bank, no row
        '{11, 1'b0, 1'b1, 2'd0, 0, 5, 2,  9, 1'b0,  0,  7}, // R7 open row 5
        '{12, 1'b1, 1'b0, 2'd0, 0, 5, 0,  0, 1'b0, 15,  4}, // R4 hit before tRAS
        '{13, 1'b1, 1'b0, 2'd0, 0, 7, 0,  0, 1'b0, 23,  5}, // R5 miss with stall
        '{14, 1'b0, 1'b1, 2'd0, 0, 7, 0, 12, 1'b1,  0,  9}, // R9 auto_pre ignored
        '{15, 1'b1, 1'b0, 2'd0, 0, 7, 0,  0, 1'b0, 16,  9}, // R9 row 7 still open
        '{20, 1'b0, 1'b1, 2'd1, 1, 3, 1,  9, 1'b1,  0,  8}, // R8 adaptive close
        '{21, 1'b1, 1'b0, 2'd1, 1, 3, 0,  0, 1'b0, 23,  8}, // R8 closed, free 35
        '{30, 1'b0, 1'b1, 2'd2, 2, 9, 0,  9, 1'b0,  0, 10}, // R10 close issue
        '{31, 1'b1, 1'b0, 2'd2, 2, 9, 0,  0, 1'b0, 22, 10}, // R10 closed, free 44
        '{32, 1'b1, 1'b0, 2'd0, 1, 3, 0,  0, 1'b0, 12, 12}, // R12 bank1 untouched
        '{33, 1'b1, 1'b0, 2'd0, 0, 7, 0,  0, 1'b0,  5,  4}, // R4 hit, no wait
        '{40, 1'b0, 1'b1, 2'd1, 3, 1, 0,  9, 1'b0,  0,  7}, // R7 adaptive keeps
        '{41, 1'b1, 1'b0, 2'd1, 3, 1, 0,  0, 1'b0, 13,  4}, // R4 adaptive hit
        '{42, 1'b1, 1'b0, 2'd1, 3, 2, 0,  0, 1'b0, 21,  5}, // R5 adaptive miss
        '{60, 1'b1, 1'b1, 2'd0, 4, 6, 0,  9, 1'b0,  9, 11}, // R11 same cycle
        '{61, 1'b1, 1'b0, 2'd0, 4, 6, 0,  0, 1'b0, 13, 11}, // R11 new row visible
        '{70, 1'b1, 1'b0, 2'd2, 0, 7, 0,  0, 1'b0,  9, 10}, // R10 open row ignored
        '{71, 1'b1, 1'b0, 2'd0, 2, 9, 0,  0, 1'b0,  9, 12}  // R12 bank2 idle by 71
    };

    task automatic check(input int req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin : main
        int c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, "lat_valid in reset", lat_valid, 0);
        check(1, "cycle_now in reset", cycle_now, 0);
        rst = 1'b0;
        check(1, "cycle_now right after reset", cycle_now, 0);
        // R2 counter advance
        c0 = cycle_now;
        repeat (5) @(negedge clk);
        check(2, "cycle_now advance", cycle_now, c0 + 5);

        for (int k = 0; k < NV; k++) begin
            while (cycle_now != 32'(VECS[k].at)) @(negedge clk);
            page_mode    = VECS[k].mode;
            q_valid      = VECS[k].q;
            q_bank       = 3'(VECS[k].bank);
            q_row        = 14'(VECS[k].row);
            iss_valid    = VECS[k].i;
            iss_bank     = 3'(VECS[k].bank);
            iss_row      = 14'(VECS[k].row);
            iss_add_dly  = 16'(VECS[k].add);
            iss_acc_lat  = 16'(VECS[k].acc);
            iss_auto_pre = VECS[k].ap;
            @(negedge clk);
            q_valid   = 1'b0;
            iss_valid = 1'b0;
            check(3, $sformatf("lat_valid vec %0d", k), lat_valid, VECS[k].q);
            if (VECS[k].q)
                check(VECS[k].req, $sformatf("lat vec %0d", k), lat, VECS[k].exp);
        end

        // R3 pulse ends one cycle after the query
        @(negedge clk);
        check(3, "lat_valid drops after pulse", lat_valid, 0);
        q_valid = 1'b1; q_bank = 3'd5; q_row = 14'd0; page_mode = 2'd0;
        @(negedge clk);
        q_valid = 1'b0;
        check(3, "lat_valid pulse", lat_valid, 1);
        check(6, "untouched bank miss cost", lat, 9);
        @(negedge clk);
        check(3, "lat_valid single cycle", lat_valid, 0);

        // R1 reset again clears an open row: bank 0 row 7 must miss
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, "cycle_now after second reset", cycle_now, 0);
        q_valid = 1'b1; q_bank = 3'd0; q_row = 14'd7; page_mode = 2'd0;
        @(negedge clk);
        q_valid = 1'b0;
        check(1, "bank0 cleared by reset", lat, 9);

        finish_run();
    end

endmodule